// File: doc/BRIEF.md
# Unaligned Load Aligner

The block turns a load request (byte address, access size, signed flag) into a 32-bit register value taken from a memory port that is twice the register width. The address picks a double-width word and a byte offset inside it. The offset drives a byte-granular barrel shifter that moves the requested bytes to the low end of the result. A load that fits inside one double-width word needs a single fetch. A load that runs past the end of the word fetches the next word as well and joins the two, little-endian.

Bytes and halfwords are zero-extended or sign-extended according to the signed flag. A strict input enables alignment checking. With it set, any load whose address is not a multiple of its size returns a fault, carries zero data and makes no fetch.

Requests use a valid/ready handshake. The response is held until the consumer takes it. The memory port returns data on the clock after a fetch is issued.

Top module: `load_aligner`

## Requirements
- R1: While reset is applied, and just after it is released, req_ready_o is 1, resp_valid_o is 0 and mem_req_o is 0.
- R2: Size encoding 0 is a byte load. The byte at the request address appears in bits 7:0 of the result, at every offset 0 to 7.
- R3: Sizes 0 (byte) and 1 (halfword) fill the upper result bits with zeros when req_signed_i is 0. They fill them with copies of the top loaded bit when req_signed_i is 1. Size 2 (word) is returned unchanged.
- R4: A load whose bytes all fall in one 8-byte word makes exactly one fetch, at word index addr>>3. Its response is valid one clock after the acceptance edge.
- R5: A load with (addr mod 8) + size_bytes > 8 makes two fetches, at indices addr>>3 and addr>>3 + 1. Its response is valid two clocks after acceptance.
- R6: With strict_i set, a load whose address is not a multiple of its size (1, 2 or 4 bytes) responds on the acceptance edge with resp_fault_o=1 and resp_data_o=0, and makes no fetch.
- R7: With strict_i set, a naturally aligned load returns normal data with resp_fault_o=0 and makes a single fetch.
- R8: While a response is waiting with resp_ready_i low, resp_data_o and resp_fault_o stay stable and req_ready_o stays 0. After the response handshake, req_ready_o returns to 1.
- R9: Results are little-endian. The byte at address a+i lands in result bits 8i+7:8i, including across a word boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Load request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_addr_i | input | AW | Byte address |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| req_signed_i | input | 1 | Sign-extend byte or halfword |
| strict_i | input | 1 | Alignment checking enable |
| mem_req_o | output | 1 | Fetch strobe |
| mem_addr_o | output | AW-3 | Double-width word index |
| mem_rdata_i | input | 2*REG_W | Fetched word, valid one clock after mem_req_o |
| resp_valid_o | output | 1 | Response valid |
| resp_ready_i | input | 1 | Consumer accepts response |
| resp_data_o | output | REG_W | Aligned and extended data |
| resp_fault_o | output | 1 | Alignment fault |

## Verification
A stale shift amount or a wrong stitch order shows up at once in the response data. The wrong bytes appear in the wrong lanes on the same response. A mistake in boundary-crossing detection shows up at the fetch port on that transaction: the number of fetches is wrong, the second index is wrong, or the response arrives a clock early or late. A fault decode error shows up on the acceptance edge as a fault flag, a fetch where none belongs, or a missing one.

// File: rtl/load_align_pkg.sv
package load_align_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} size_e;

  function automatic int size_bytes(input logic [1:0] sz, input int reg_b);
    case (sz)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return reg_b;
    endcase
  endfunction
endpackage

// File: rtl/align_check.sv
module align_check import load_align_pkg::*; #(
  parameter int REG_W   = 32,
  parameter int FETCH_B = 8,
  localparam int OFF_W  = $clog2(FETCH_B)
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       size_i,
  input  logic             strict_i,
  output logic             fault_o,
  output logic             split_o
);
  logic [OFF_W:0] nb, last;

  always_comb begin
    nb      = (OFF_W+1)'(size_bytes(size_i, REG_W/8));
    last    = {1'b0, off_i} + nb - (OFF_W+1)'(1);
    split_o = last[OFF_W];
    fault_o = strict_i && ((off_i & (nb[OFF_W-1:0] - OFF_W'(1))) != '0);
  end

  always_comb begin
    if (size_i == SZ_BYTE) p_byte_no_split_r5: assert (!split_o);
    if (off_i == '0)       p_off0_no_fault_r7: assert (!fault_o);
  end
endmodule

// File: rtl/align_shifter.sv
module align_shifter #(
  parameter int REG_W   = 32,
  parameter int FETCH_W = 64,
  localparam int OFF_W  = $clog2(FETCH_W/8),
  localparam int WIN_W  = 2*FETCH_W
) (
  input  logic [WIN_W-1:0] win_i,
  input  logic [OFF_W-1:0] shamt_i,
  output logic [REG_W-1:0] data_o
);
  logic [WIN_W-1:0] stage [OFF_W+1];
  assign stage[0] = win_i;

  // log-depth byte shifter: stage s moves by 2^s bytes
  for (genvar s = 0; s < OFF_W; s++) begin : g_stage
    assign stage[s+1] = shamt_i[s] ? (stage[s] >> (8 << s)) : stage[s];
  end

  assign data_o = REG_W'(stage[OFF_W]);
endmodule

// File: rtl/load_extend.sv
module load_extend import load_align_pkg::*; #(
  parameter int REG_W = 32
) (
  input  logic [REG_W-1:0] raw_i,
  input  logic [1:0]       size_i,
  input  logic             signed_i,
  output logic [REG_W-1:0] data_o
);
  always_comb begin
    case (size_i)
      SZ_BYTE: data_o = {{(REG_W-8){signed_i & raw_i[7]}}, raw_i[7:0]};
      SZ_HALF: data_o = {{(REG_W-16){signed_i & raw_i[15]}}, raw_i[15:0]};
      default: data_o = raw_i;
    endcase
  end

  always_comb begin
    if (size_i == SZ_BYTE && !signed_i) p_zext_byte_r3: assert (data_o[REG_W-1:8] == '0);
    if (size_i == SZ_HALF && signed_i)  p_sext_half_r3: assert (data_o[REG_W-1] == data_o[15]);
  end
endmodule

// File: rtl/load_aligner.sv
module load_aligner import load_align_pkg::*; #(
  parameter int REG_W = 32,
  parameter int AW    = 32,
  localparam int FETCH_W = 2*REG_W,
  localparam int FETCH_B = FETCH_W/8,
  localparam int OFF_W   = $clog2(FETCH_B),
  localparam int IDX_W   = AW - OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [AW-1:0]      req_addr_i,
  input  logic [1:0]         req_size_i,
  input  logic               req_signed_i,
  input  logic               strict_i,
  output logic               mem_req_o,
  output logic [IDX_W-1:0]   mem_addr_o,
  input  logic [FETCH_W-1:0] mem_rdata_i,
  output logic               resp_valid_o,
  input  logic               resp_ready_i,
  output logic [REG_W-1:0]   resp_data_o,
  output logic               resp_fault_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_SECOND, ST_RESP} state_e;

  state_e             state_q;
  logic [OFF_W-1:0]   off_q;
  logic [IDX_W-1:0]   idx_q;
  logic [1:0]         size_q;
  logic               sgn_q, split_q;
  logic [FETCH_W-1:0] lo_q;
  logic [REG_W-1:0]   data_q;
  logic               fault_q;

  logic fault_w, split_w, accept;
  logic [2*FETCH_W-1:0] win;
  logic [REG_W-1:0] raw, ext;

  align_check #(.REG_W(REG_W), .FETCH_B(FETCH_B)) u_check (
    .off_i(req_addr_i[OFF_W-1:0]), .size_i(req_size_i), .strict_i(strict_i),
    .fault_o(fault_w), .split_o(split_w)
  );

  assign req_ready_o  = (state_q == ST_IDLE);
  assign accept       = req_valid_i && req_ready_o;
  assign mem_req_o    = (accept && !fault_w) || (state_q == ST_FIRST && split_q);
  assign mem_addr_o   = (state_q == ST_IDLE) ? req_addr_i[AW-1:OFF_W] : idx_q + IDX_W'(1);
  assign resp_valid_o = (state_q == ST_RESP);
  assign resp_data_o  = data_q;
  assign resp_fault_o = fault_q;

  // second fetch supplies the high half of the window
  assign win = (state_q == ST_SECOND) ? {mem_rdata_i, lo_q} : {FETCH_W'(0), mem_rdata_i};

  align_shifter #(.REG_W(REG_W), .FETCH_W(FETCH_W)) u_shift (
    .win_i(win), .shamt_i(off_q), .data_o(raw)
  );

  load_extend #(.REG_W(REG_W)) u_ext (
    .raw_i(raw), .size_i(size_q), .signed_i(sgn_q), .data_o(ext)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      off_q   <= '0;
      idx_q   <= '0;
      size_q  <= '0;
      sgn_q   <= 1'b0;
      split_q <= 1'b0;
      lo_q    <= '0;
      data_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          off_q   <= req_addr_i[OFF_W-1:0];
          idx_q   <= req_addr_i[AW-1:OFF_W];
          size_q  <= req_size_i;
          sgn_q   <= req_signed_i;
          split_q <= split_w;
          if (fault_w) begin
            data_q  <= '0;
            fault_q <= 1'b1;
            state_q <= ST_RESP;
          end else begin
            fault_q <= 1'b0;
            state_q <= ST_FIRST;
          end
        end
        ST_FIRST: if (split_q) begin
          lo_q    <= mem_rdata_i;
          state_q <= ST_SECOND;
        end else begin
          data_q  <= ext;
          state_q <= ST_RESP;
        end
        ST_SECOND: begin
          data_q  <= ext;
          state_q <= ST_RESP;
        end
        default: if (resp_ready_i) state_q <= ST_IDLE;
      endcase
    end
  end

  p_busy_not_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> !req_ready_o);
  p_hold_resp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && !resp_ready_i |=> resp_valid_o && $stable(resp_data_o) && $stable(resp_fault_o));
  p_fault_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && resp_fault_o |-> resp_data_o == '0);
  p_fault_fast_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(resp_valid_o) && resp_fault_o |-> $past(accept));
  p_next_word_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !req_ready_o |-> mem_addr_o == $past(mem_addr_o) + IDX_W'(1));
  p_fetch_before_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(resp_valid_o) && !resp_fault_o |-> $past(mem_req_o, 2));
endmodule

// File: tb/load_aligner_bench.sv
module load_aligner_bench;
  localparam int REG_W = 32, AW = 32, IDX_W = AW - 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_signed = 1'b0, strict = 1'b0, resp_ready = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic mem_req, req_ready, resp_valid, resp_fault;
  logic [IDX_W-1:0] mem_addr;
  logic [2*REG_W-1:0] mem_rdata = '0;
  logic [REG_W-1:0] resp_data;
  int checks = 0, errors = 0, fetch_n = 0;
  logic [IDX_W-1:0] last_idx = '0;

  always #2 clk = ~clk;

  load_aligner #(.REG_W(REG_W), .AW(AW)) u_load_aligner (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_signed_i(req_signed),
    .strict_i(strict), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rdata_i(mem_rdata), .resp_valid_o(resp_valid), .resp_ready_i(resp_ready),
    .resp_data_o(resp_data), .resp_fault_o(resp_fault)
  );

  function automatic logic [7:0] mb(input logic [AW-1:0] a);
    return 8'(a * 32'd29 + (a >> 7) * 32'd11 + 32'd3);
  endfunction

  function automatic logic [63:0] mword(input logic [IDX_W-1:0] idx);
    logic [63:0] w;
    for (int i = 0; i < 8; i++) w[i*8 +: 8] = mb({idx, 3'b000} + AW'(i));
    return w;
  endfunction

  always @(posedge clk) begin
    if (mem_req) begin
      mem_rdata <= mword(mem_addr);
      fetch_n++;
      last_idx = mem_addr;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [AW-1:0] a, input logic [1:0] sz, input bit sg,
                         input bit st, input int hold, input string tag);
    int nb, f0, cyc;
    bit fault_e, split_e;
    logic [REG_W-1:0] exp_d;
    logic [IDX_W-1:0] idx0;
    nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    fault_e = st && ((a % nb) != 0);
    split_e = ((a % 8) + nb) > 8;
    exp_d = '0;
    if (!fault_e) begin
      for (int i = 0; i < nb; i++) exp_d[i*8 +: 8] = mb(a + AW'(i));
      if (sg && nb < 4 && exp_d[nb*8-1]) for (int i = nb*8; i < REG_W; i++) exp_d[i] = 1'b1;
    end
    req_addr = a; req_size = sz; req_signed = sg; strict = st; req_valid = 1'b1;
    #0.5;
    chk(req_ready == 1'b1, {tag, " R8 ready idle"}, 64'(req_ready), 64'd1);
    idx0 = mem_addr;
    f0 = fetch_n;
    @(posedge clk); #1;
    req_valid = 1'b0;
    cyc = 0;
    while (!resp_valid && cyc < 10) begin @(posedge clk); #1; cyc++; end
    chk(resp_fault == fault_e, {tag, " R6 fault flag"}, 64'(resp_fault), 64'(fault_e));
    chk(resp_data == exp_d, {tag, " R2 R3 R9 data"}, 64'(resp_data), 64'(exp_d));
    if (fault_e) begin
      chk(cyc == 0 && fetch_n == f0, {tag, " R6 no fetch, same edge"}, 64'(cyc), 64'd0);
    end else if (split_e) begin
      chk(cyc == 2 && fetch_n == f0 + 2, {tag, " R5 two fetches"}, 64'(fetch_n - f0), 64'd2);
      chk(last_idx == idx0 + 1 && idx0 == a[AW-1:3], {tag, " R5 fetch index"},
          64'(last_idx), 64'(a[AW-1:3] + 1));
    end else begin
      chk(cyc == 1 && fetch_n == f0 + 1, {tag, " R4 R7 one fetch"}, 64'(fetch_n - f0), 64'd1);
      chk(idx0 == a[AW-1:3], {tag, " R4 fetch index"}, 64'(idx0), 64'(a[AW-1:3]));
    end
    for (int h = 0; h < hold; h++) begin
      @(posedge clk); #1;
      chk(resp_valid && !req_ready && resp_data == exp_d && resp_fault == fault_e,
          {tag, " R8 held"}, 64'(resp_data), 64'(exp_d));
    end
    resp_ready = 1'b1;
    @(posedge clk); #1;
    resp_ready = 1'b0;
    chk(!resp_valid && req_ready, {tag, " R8 released"}, 64'(resp_valid), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    #1;
    chk(req_ready && !resp_valid && !mem_req, "R1 in reset", 64'({req_ready, resp_valid, mem_req}), 64'b100);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    chk(req_ready && !resp_valid && !mem_req, "R1 after reset", 64'({req_ready, resp_valid, mem_req}), 64'b100);
    for (int o = 0; o < 8; o++) do_load(32'h100 + o, 2'd0, 1'b0, 1'b0, 0, "R2 byte");
    for (int o = 0; o < 16; o++) do_load(32'h200 + o, 2'd0, 1'b1, 1'b0, 0, "R3 sbyte");
    do_load(32'h307, 2'd1, 1'b1, 1'b0, 0, "R5 half cross");
    do_load(32'h306, 2'd1, 1'b0, 1'b0, 0, "R4 half end");
    do_load(32'h404, 2'd2, 1'b0, 1'b0, 0, "R4 word hi");
    do_load(32'h405, 2'd2, 1'b0, 1'b0, 0, "R9 word cross");
    do_load(32'h407, 2'd2, 1'b0, 1'b0, 2, "R5 word cross7");
    do_load(32'h501, 2'd1, 1'b0, 1'b1, 0, "R6 strict half");
    do_load(32'h502, 2'd2, 1'b0, 1'b1, 3, "R6 strict word");
    do_load(32'h504, 2'd2, 1'b0, 1'b1, 0, "R7 strict word");
    do_load(32'h503, 2'd0, 1'b1, 1'b1, 0, "R7 strict byte");
    do_load(32'hFFFF_FFFC, 2'd2, 1'b0, 1'b0, 0, "R4 top word");
    for (int n = 0; n < 400; n++)
      do_load(AW'($urandom % 4096), 2'($urandom % 3), 1'($urandom), ($urandom % 4) == 0,
              int'($urandom % 3), "rand");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule